// File: doc/BRIEF.md
# Timer/Counter with Programmable Prescaler

This block is an 8-bit timer/counter that sits on a small processor's data bus. Every clock of `clk` is one instruction cycle. The counter has two possible count sources:

- the instruction cycle itself, or
- transitions on an external timer clock pin, with the active edge selectable.

An 8-bit prescaler can sit between the count source and the counter. Its divide ratio is set by a 3-bit rate field. Alternatively, the prescaler can be handed over to the watchdog. In that case it divides the watchdog's tick stream, the counter counts every source event directly, and the prescaler's carry and clear signals appear on ports for the watchdog logic.

Software reads and writes the counter at data address 01h. A write reloads the counter, clears the prescaler, and freezes counting for two instruction cycles. A small state machine enforces this freeze. Its states are:

- `ST_RUN`: counting allowed.
- `ST_HOLD_A`: first frozen cycle.
- `ST_HOLD_B`: second frozen cycle.

Its transitions are:

- load (any state to `ST_HOLD_A`)
- `ST_HOLD_A` to `ST_HOLD_B`
- `ST_HOLD_B` to `ST_RUN`
- `ST_RUN` to `ST_RUN` while no load occurs.

When the counter wraps from FFh to 00h, a one-cycle overflow pulse is produced. The surrounding interrupt logic uses this pulse to set its Timer0 flag, which is bit 0 of the flag register at 0Fh.

The control word is loaded through a dedicated option write strobe. Its fields are:

| Bits | Field |
|------|-------|
| 5 | source select: 0 = instruction cycle, 1 = pin |
| 4 | edge select: 0 = rising, 1 = falling |
| 3 | prescaler owner: 0 = timer, 1 = watchdog |
| 2:0 | rate |

Top module: `tmr_count_unit`

## Requirements
- R1: After reset the counter is 00h, the control word is 0 (instruction-cycle source, rising edge, prescaler on the timer, rate 0), and `ovf_pulse` and `ps_carry` are low.
- R2: A bus write with `bus_addr` = 01h loads `bus_wdata` into the counter. `bus_rdata` returns the counter when `bus_addr` = 01h and 00h for any other address. Writes to other addresses leave the counter, the prescaler and the freeze untouched.
- R3: With control bit 5 = 0 and bit 3 = 1, the counter increments by one on every cycle it is allowed to count.
- R4: After the cycle of a counter write, the counter does not change for the next two cycles. It counts again in the third cycle.
- R5: With bit 3 = 0 and rate r in bits 2:0, the counter advances once per 2^(r+1) source events. The prescaler is cleared by a counter write and by an option write.
- R6: With bit 5 = 1, the pin passes through a two-flop synchronizer. Bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges. One count occurs per edge when bit 3 = 1.
- R7: On a count from FFh to 00h, `ovf_pulse` is high for exactly the one cycle in which the counter reads 00h. Writing 00h does not raise it.
- R8: With bit 3 = 1, the prescaler advances on `wdt_tick`, and `ps_carry` is high in the cycle of every 2^(r+1)-th tick. `wdt_clr` restarts the division. With bit 3 = 0, `ps_carry` stays low, and `wdt_tick` and `wdt_clr` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Data bus address |
| bus_wr | input | 1 | Data bus write strobe |
| bus_wdata | input | 8 | Data bus write data |
| bus_rdata | output | 8 | Counter value when addressed, else 0 |
| opt_wr | input | 1 | Control word write strobe |
| opt_wdata | input | 6 | Control word (bit 5 source, 4 edge, 3 owner, 2:0 rate) |
| tck_pin | input | 1 | External timer clock pin |
| wdt_tick | input | 1 | Watchdog tick, divided when the prescaler belongs to the watchdog |
| wdt_clr | input | 1 | Watchdog clear of the prescaler |
| ps_carry | output | 1 | Prescaler carry to the watchdog |
| ovf_pulse | output | 1 | One-cycle counter wrap pulse |

## Verification
The bench targets the following corner cases, and what a wrong design would show for each:

- **Freeze after a write.** A design that counted too early would show the reloaded value plus one a cycle ahead of time.
- **Wrap from FFh.** A misplaced overflow pulse would appear against a counter value other than 00h, or would appear after a write of 00h.
- **Prescaler ratios of 1:2 and 1:8, with clears from both write strobes.** A design that failed to clear the prescaler would tick early after a reload.
- **Edge polarity on the synchronized pin.** A design with inverted polarity would count on the wrong half of each pulse.
- **Watchdog ownership.** A design leaking ownership would emit carries, or divide timer events, under the wrong owner.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD_A = 2'd1,
        ST_HOLD_B = 2'd2
    } hold_st_t;

    // Control word: MSB first packs to bit 5 down to bit 0
    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        logic              ps_to_wdt;
        logic [RATE_W-1:0] rate;
    } tmr_opt_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic ev
);
    logic [SYNC_N:0] sh_q;
    logic            cur_lvl;
    logic            prev_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_N-1:0], pin};
        end
    end

    always_comb begin
        cur_lvl  = sh_q[SYNC_N-1] ^ edge_fall;
        prev_lvl = sh_q[SYNC_N] ^ edge_fall;
        ev       = cur_lvl & ~prev_lvl;
    end

    // R6: an edge of one polarity cannot be seen on two consecutive cycles
    a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && $stable(edge_fall)) |=> !(ev && $stable(edge_fall)));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int RATE_W = 3,
    localparam int PS_W = 1 << RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (32'(rate) >= i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (clr) begin
            ps_q <= '0;
        end else if (adv) begin
            ps_q <= ps_q + 1'b1;
        end
    end

    assign tick = adv & ~clr & ((ps_q & mask) == mask);

    // R5: the smallest ratio is 1:2, so two ticks never follow each other
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_hold_fsm.sv
module tmr_hold_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic run_ok
);
    hold_st_t st_q;
    hold_st_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:    st_d = load ? ST_HOLD_A : ST_RUN;
            ST_HOLD_A: st_d = load ? ST_HOLD_A : ST_HOLD_B;
            ST_HOLD_B: st_d = load ? ST_HOLD_A : ST_RUN;
            default:   st_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_ok = (st_q == ST_RUN);
    end

    // R4: a load always enters the first frozen state
    a_r4_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q == ST_HOLD_A));
    // R4: the first frozen cycle is followed by the second
    a_r4_hold_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD_A && !load) |=> (st_q == ST_HOLD_B));
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int               CNT_W    = 8,
    parameter int               ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 6'h01,
    parameter int               SYNC_N   = 2,
    localparam int              OPT_W    = $bits(tmr_opt_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              opt_wr,
    input  logic [OPT_W-1:0]  opt_wdata,
    input  logic              tck_pin,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    output logic              ps_carry,
    output logic              ovf_pulse
);
    tmr_opt_t        opt_q;
    logic [CNT_W-1:0] cnt_q;
    logic            cnt_we;
    logic            run_ok;
    logic            run_now;
    logic            ext_ev;
    logic            src_ev;
    logic            ps_adv;
    logic            ps_clr;
    logic            ps_tick;
    logic            cnt_inc;

    assign cnt_we = bus_wr && (bus_addr == CNT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= '0;
        end else if (opt_wr) begin
            opt_q <= tmr_opt_t'(opt_wdata);
        end
    end

    tmr_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (tck_pin),
        .edge_fall (opt_q.edge_fall),
        .ev        (ext_ev)
    );

    tmr_hold_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_we),
        .run_ok (run_ok)
    );

    always_comb begin
        run_now = run_ok & ~cnt_we;
        src_ev  = opt_q.src_ext ? ext_ev : 1'b1;
        ps_adv  = opt_q.ps_to_wdt ? wdt_tick : (src_ev & run_now);
        ps_clr  = opt_wr | cnt_we | (opt_q.ps_to_wdt & wdt_clr);
        cnt_inc = run_now & (opt_q.ps_to_wdt ? src_ev : ps_tick);
    end

    tmr_prescaler #(.RATE_W(RATE_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ps_clr),
        .adv   (ps_adv),
        .rate  (opt_q.rate),
        .tick  (ps_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= cnt_inc && (cnt_q == {CNT_W{1'b1}});
            if (cnt_we) begin
                cnt_q <= bus_wdata;
            end else if (cnt_inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ps_carry  = opt_q.ps_to_wdt & ps_tick;
    assign bus_rdata = (bus_addr == CNT_ADDR) ? cnt_q : '0;

    // R4: while frozen and not reloaded the counter keeps its value
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !cnt_we) |=> $stable(cnt_q));
    // R3: direct instruction-cycle counting advances by one
    a_r3_direct_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q.ps_to_wdt && !opt_q.src_ext && run_ok && !cnt_we && !opt_wr)
        |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R7: the wrap pulse coincides with a zero counter
    a_r7_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt_q == '0));
    // R7: the wrap pulse follows an all-ones counter
    a_r7_ovf_from_max: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($past(cnt_q) == {CNT_W{1'b1}}));
    // R8: the carry appears only while the watchdog owns the prescaler
    a_r8_carry_owner: assert property (@(posedge clk) disable iff (!rst_n)
        ps_carry |-> opt_q.ps_to_wdt);
endmodule

// File: tb/tmr_count_unit_bench.sv
module tmr_count_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = 6'h01;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       opt_wr = 1'b0;
    logic [5:0] opt_wdata = 6'h00;
    logic       tck_pin = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       ps_carry;
    logic       ovf_pulse;

    int    n_checks = 0;
    int    n_errors = 0;
    int    carry_seen = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tmr_count_unit u_tmr_count_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .opt_wr    (opt_wr),
        .opt_wdata (opt_wdata),
        .tck_pin   (tck_pin),
        .wdt_tick  (wdt_tick),
        .wdt_clr   (wdt_clr),
        .ps_carry  (ps_carry),
        .ovf_pulse (ovf_pulse)
    );

    // Behavioural reference model
    int m_cnt = 0, m_ps = 0, m_hold = 0, m_ovf = 0;
    bit [5:0] m_opt = '0;
    bit pin_hist[$] = '{1'b0, 1'b0, 1'b0};

    function automatic bit ps_full(int ps, int rate);
        int r;
        r = 1 << (rate + 1);
        return (ps % r) == (r - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_hold = 0; m_ovf = 0; m_opt = '0;
            pin_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit lvl_now, lvl_old, ext, src, wr, clr, run, adv, tk, inc;
            bit psa;
            int rate;
            psa     = m_opt[3];
            rate    = int'(m_opt[2:0]);
            lvl_now = pin_hist[1] ^ m_opt[4];
            lvl_old = pin_hist[2] ^ m_opt[4];
            ext     = lvl_now && !lvl_old;
            src     = m_opt[5] ? ext : 1'b1;
            wr      = bus_wr && (bus_addr == 6'h01);
            clr     = opt_wr || wr || (psa && wdt_clr);
            run     = (m_hold == 0) && !wr;
            adv     = psa ? wdt_tick : (src && run);
            tk      = adv && ps_full(m_ps, rate) && !clr;
            inc     = run && (psa ? src : tk);
            m_ovf   = (inc && m_cnt == 255) ? 1 : 0;
            if (wr) m_cnt = int'(bus_wdata);
            else if (inc) m_cnt = (m_cnt + 1) % 256;
            if (clr) m_ps = 0;
            else if (adv) m_ps = (m_ps + 1) % 256;
            if (wr) m_hold = 2;
            else if (m_hold > 0) m_hold = m_hold - 1;
            if (opt_wr) m_opt = opt_wdata;
            pin_hist.push_front(tck_pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit e_carry;
            bit wr;
            wr = bus_wr && (bus_addr == 6'h01);
            e_carry = m_opt[3] && wdt_tick && ps_full(m_ps, int'(m_opt[2:0]))
                      && !(opt_wr || wr || wdt_clr);
            chk(cur_req, int'(bus_rdata), (bus_addr == 6'h01) ? m_cnt : 0, "bus_rdata");
            chk(cur_req, int'(ovf_pulse), m_ovf, "ovf_pulse");
            chk(cur_req, int'(ps_carry), int'(e_carry), "ps_carry");
            if (ps_carry) carry_seen++;
        end
    end

    task automatic at_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h01;
    endtask

    task automatic do_opt(input logic [5:0] d);
        @(negedge clk);
        opt_wdata = d; opt_wr = 1'b1;
        @(negedge clk);
        opt_wr = 1'b0;
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        @(negedge clk);
        tck_pin = 1'b1;
        repeat (hi) @(negedge clk);
        tck_pin = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic wdt_pulse();
        @(negedge clk);
        wdt_tick = 1'b1;
        @(negedge clk);
        wdt_tick = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        at_edge();
        // R1: reset state
        chk("R1", int'(bus_rdata), 0, "reset count");
        chk("R1", int'(ovf_pulse), 0, "reset ovf");
        chk("R1", int'(ps_carry), 0, "reset carry");

        // R4 and R3: freeze then direct counting
        cur_req = "R4";
        do_opt(6'h08);
        do_wr(6'h01, 8'h10);
        at_edge(); chk("R4", int'(bus_rdata), 8'h10, "hold 1");
        at_edge(); chk("R4", int'(bus_rdata), 8'h10, "hold 2");
        at_edge(); chk("R4", int'(bus_rdata), 8'h11, "resume");
        cur_req = "R3";
        at_edge(); chk("R3", int'(bus_rdata), 8'h12, "direct count");

        // R2: other addresses
        cur_req = "R2";
        do_wr(6'h03, 8'h55);
        at_edge(); v = int'(bus_rdata);
        at_edge(); chk("R2", int'(bus_rdata), (v + 1) % 256, "foreign write ignored");
        @(negedge clk); bus_addr = 6'h03;
        at_edge(); chk("R2", int'(bus_rdata), 0, "foreign read zero");
        @(negedge clk); bus_addr = 6'h01;

        // R7: wrap
        cur_req = "R7";
        do_wr(6'h01, 8'hFE);
        at_edge(); at_edge();
        at_edge(); chk("R7", int'(bus_rdata), 8'hFF, "before wrap");
        at_edge(); chk("R7", int'(bus_rdata), 8'h00, "wrapped");
        chk("R7", int'(ovf_pulse), 1, "ovf on wrap");
        at_edge(); chk("R7", int'(ovf_pulse), 0, "ovf one cycle");
        do_wr(6'h01, 8'h00);
        at_edge(); chk("R7", int'(ovf_pulse), 0, "no ovf on write");

        // R5: prescaler 1:8 then 1:2
        cur_req = "R5";
        do_opt(6'h02);
        do_wr(6'h01, 8'h00);
        repeat (9) at_edge();
        chk("R5", int'(bus_rdata), 0, "1:8 before tick");
        at_edge(); chk("R5", int'(bus_rdata), 1, "1:8 tick");
        do_opt(6'h00);
        do_wr(6'h01, 8'h00);
        at_edge(); at_edge(); at_edge();
        chk("R5", int'(bus_rdata), 0, "1:2 first event");
        at_edge(); chk("R5", int'(bus_rdata), 1, "1:2 tick");

        // R6: external rising then falling edges
        cur_req = "R6";
        do_opt(6'h28);
        do_wr(6'h01, 8'h00);
        repeat (3) at_edge();
        for (int i = 0; i < 3; i++) pin_pulse(3, 3);
        repeat (4) at_edge();
        chk("R6", int'(bus_rdata), 3, "rising edges");
        do_opt(6'h38);
        do_wr(6'h01, 8'h00);
        repeat (3) at_edge();
        pin_pulse(3, 3);
        @(negedge clk); tck_pin = 1'b1;
        repeat (4) at_edge();
        chk("R6", int'(bus_rdata), 1, "falling only");
        @(negedge clk); tck_pin = 1'b0;
        repeat (4) at_edge();
        chk("R6", int'(bus_rdata), 2, "falling edges");

        // R8: prescaler owned by watchdog
        cur_req = "R8";
        do_opt(6'h0B);
        carry_seen = 0;
        for (int i = 0; i < 32; i++) wdt_pulse();
        at_edge();
        chk("R8", carry_seen, 2, "carries at 1:16");
        carry_seen = 0;
        for (int i = 0; i < 10; i++) wdt_pulse();
        @(negedge clk); wdt_clr = 1'b1;
        @(negedge clk); wdt_clr = 1'b0;
        for (int i = 0; i < 16; i++) wdt_pulse();
        at_edge();
        chk("R8", carry_seen, 1, "carry after clear");
        do_opt(6'h03);
        carry_seen = 0;
        for (int i = 0; i < 32; i++) begin
            wdt_pulse();
            @(negedge clk); wdt_clr = 1'b1;
            @(negedge clk); wdt_clr = 1'b0;
        end
        at_edge();
        chk("R8", carry_seen, 0, "no carry when timer owns");

        // Mixed traffic against the model
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tck_pin  = ($urandom % 4) == 0 ? ~tck_pin : tck_pin;
            wdt_tick = ($urandom % 3) == 0;
            wdt_clr  = ($urandom % 40) == 0;
            bus_wr   = ($urandom % 50) == 0;
            bus_addr = (($urandom % 4) == 0) ? 6'h05 : 6'h01;
            bus_wdata = 8'($urandom);
            opt_wr   = ($urandom % 120) == 0;
            opt_wdata = 6'($urandom);
        end
        @(negedge clk);
        bus_wr = 1'b0; opt_wr = 1'b0; wdt_tick = 1'b0; wdt_clr = 1'b0;
        at_edge();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule